// File: doc/BRIEF.md
# Dataflow Execution Unit with Destination Fan-Out

This block is the execution stage of a small token-driven dataflow processor. Upstream logic that pairs operands delivers an extended token. It carries two 16-bit operands, a two-bit operation code, and up to four optional destinations. The block queues each extended token in its own input FIFO and computes the add, subtract or multiply result in the cycle the token reaches the FIFO head, with no pipelining. It then emits one result token for each valid destination toward the router's internal input.

The result tokens leave one at a time, in ascending destination index. Invalid destination slots are skipped. A downstream full flag stalls the stream, and while it is high the presented token stays unchanged. An extended token leaves the FIFO only when its last result token is accepted. An extended token with no valid destination is dropped in a single cycle. The FIFO raises a full flag toward the producer so that the producer stops sending while no slot is free.

Top module: `xu_exec_unit`

## Requirements
- R1: Operation code 0 is addition. The result is the 16-bit two's-complement sum, wrapping on overflow (32767 + 1 gives -32768).
- R2: Operation code 1 is subtraction, left operand minus right operand (7 and 35 give -28).
- R3: Operation code 2 is multiplication, and only the low 16 bits of the product are kept (300 times 300 gives 24464).
- R4: Each result token carries the 16-bit result, a 7-bit node number and a side flag, where 0 is the left input and 1 is the right input. Destination slot k uses bits [7k+6:7k] of `in_dst_node` and bit k of `in_dst_side`, and it is valid when bit k of `in_dst_vld` is 1.
- R5: The result tokens of one extended token are presented in ascending slot order 0 to 3, and invalid slots are skipped.
- R6: An extended token stays at the FIFO head until its last valid result token is accepted (`out_valid` high and `out_full` low). The tokens of the next entry appear only after that.
- R7: While `out_full` is high, a presented token keeps `out_valid` high and holds its value, node and side unchanged.
- R8: An extended token with no valid slot produces no output and leaves the FIFO one cycle after it reaches the head.
- R9: `in_full` is high exactly when DEPTH extended tokens are stored. A write offered while `in_full` is high is ignored.
- R10: After reset the FIFO is empty, and `out_valid` and `in_full` are low.
- R11: An extended token written into an empty FIFO is presented on the outputs in the next cycle, together with its computed result.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Extended token offered for writing |
| in_lhs | input | 16 | Left operand |
| in_rhs | input | 16 | Right operand |
| in_op | input | 2 | Operation code: 0 add, 1 subtract, 2 multiply |
| in_dst_vld | input | 4 | Valid bit for each destination slot |
| in_dst_node | input | 28 | Node numbers, 7 bits per slot |
| in_dst_side | input | 4 | Side flag for each slot, 1 means right |
| in_full | output | 1 | Input FIFO holds DEPTH entries |
| out_valid | output | 1 | Result token presented |
| out_value | output | 16 | Result value |
| out_node | output | 7 | Destination node number |
| out_side | output | 1 | Destination side |
| out_full | input | 1 | Router internal FIFO cannot accept |

## Verification
A corrupted sent-slot mask in the fan-out sequencer shows up at the ports as a repeated or skipped node number. A premature FIFO pop shows up as the next entry's result appearing early. Both become visible on the very next cycle that presents a token. A wrong FIFO occupancy shows up at once as a mistimed `in_full`, or, after a drain, as an extra or missing result. The reference model is compared with the outputs on every cycle, so such a fault is reported in the cycle it first reaches the ports.

// File: rtl/xu_pkg.sv
package xu_pkg;
   typedef enum logic [1:0] {
      XU_ADD = 2'd0,
      XU_SUB = 2'd1,
      XU_MUL = 2'd2
   } xu_op_e;
endpackage

// File: rtl/xu_fifo.sv
module xu_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wr_data,
   input  logic         pop,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   initial begin
      assert (W >= 1) else $error("xu_fifo: W must be positive");
      assert (DEPTH >= 1) else $error("xu_fifo: DEPTH must be positive");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         logic         held_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_q <= 1'b0;
            end else if (push && !held_q) begin
               held_q <= 1'b1;
            end else if (pop && held_q) begin
               held_q <= 1'b0;
            end
         end
         always_ff @(posedge clk) begin
            if (push && !held_q) slot_q <= wr_data;
         end
         assign rd_data = slot_q;
         assign empty   = !held_q;
         assign full    = held_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
         localparam logic [CW-1:0] CAP  = CW'(DEPTH);

         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wp_q, rp_q;
         logic [CW-1:0] cnt_q;
         logic          do_push, do_pop;

         assign full    = (cnt_q == CAP);
         assign empty   = (cnt_q == '0);
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;
         assign rd_data = mem_q[rp_q];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
               if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem_q[wp_q] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/xu_alu.sv
module xu_alu
   import xu_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] lhs,
   input  logic [WORD_W-1:0] rhs,
   input  logic [1:0]        op,
   output logic [WORD_W-1:0] res
);
   logic [WORD_W-1:0] prod;

   assign prod = lhs * rhs;

   always_comb begin
      case (xu_op_e'(op))
         XU_ADD:  res = lhs + rhs;
         XU_SUB:  res = lhs - rhs;
         XU_MUL:  res = prod;
         default: res = lhs + rhs;
      endcase
   end
endmodule

// File: rtl/xu_fanout.sv
module xu_fanout #(
   parameter int N_DST = 4,
   localparam int IDX_W = (N_DST > 1) ? $clog2(N_DST) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_ok,
   input  logic [N_DST-1:0] dst_vld,
   input  logic             out_full,
   output logic             out_valid,
   output logic [IDX_W-1:0] cur_idx,
   output logic             pop
);
   logic [N_DST-1:0] sent_q;
   logic [N_DST-1:0] pending, cur_bit, left_after;
   logic             any, accept;

   assign pending = dst_vld & ~sent_q;
   assign any     = |pending;

   always_comb begin
      cur_idx = '0;
      cur_bit = '0;
      for (int k = N_DST - 1; k >= 0; k--) begin
         if (pending[k]) begin
            cur_idx = IDX_W'(k);
            cur_bit = '0;
            cur_bit[k] = 1'b1;
         end
      end
   end

   assign left_after = pending & ~cur_bit;
   assign out_valid  = head_ok && any;
   assign accept     = out_valid && !out_full;
   assign pop        = head_ok && (!any || (accept && (left_after == '0)));

   always_ff @(posedge clk) begin
      if (!rst_n)      sent_q <= '0;
      else if (pop)    sent_q <= '0;
      else if (accept) sent_q <= sent_q | cur_bit;
   end
endmodule

// File: rtl/xu_exec_unit.sv
module xu_exec_unit #(
   parameter int WORD_W = 16,
   parameter int NODE_W = 7,
   parameter int N_DST  = 4,
   parameter int DEPTH  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [WORD_W-1:0]        in_lhs,
   input  logic [WORD_W-1:0]        in_rhs,
   input  logic [1:0]               in_op,
   input  logic [N_DST-1:0]         in_dst_vld,
   input  logic [N_DST*NODE_W-1:0]  in_dst_node,
   input  logic [N_DST-1:0]         in_dst_side,
   output logic                     in_full,
   output logic                     out_valid,
   output logic [WORD_W-1:0]        out_value,
   output logic [NODE_W-1:0]        out_node,
   output logic                     out_side,
   input  logic                     out_full
);
   localparam int IDX_W = (N_DST > 1) ? $clog2(N_DST) : 1;
   localparam int EXT_W = 2 * WORD_W + 2 + N_DST * (NODE_W + 2);

   initial begin
      assert (WORD_W >= 2) else $error("xu_exec_unit: WORD_W too small");
      assert (NODE_W >= 1) else $error("xu_exec_unit: NODE_W too small");
      assert (N_DST >= 1 && N_DST <= 16) else $error("xu_exec_unit: N_DST out of range");
      assert (DEPTH >= 1) else $error("xu_exec_unit: DEPTH must be positive");
   end

   logic [EXT_W-1:0]        wr_word, head_word;
   logic                    fifo_empty, fifo_pop;
   logic [WORD_W-1:0]       head_lhs, head_rhs;
   logic [1:0]              head_op;
   logic [N_DST-1:0]        head_vld, head_side;
   logic [N_DST*NODE_W-1:0] head_node;
   logic [IDX_W-1:0]        cur_idx;

   assign wr_word = {in_lhs, in_rhs, in_op, in_dst_vld, in_dst_side, in_dst_node};
   assign {head_lhs, head_rhs, head_op, head_vld, head_side, head_node} = head_word;

   xu_fifo #(.W(EXT_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (in_valid),
      .wr_data (wr_word),
      .pop     (fifo_pop),
      .rd_data (head_word),
      .empty   (fifo_empty),
      .full    (in_full)
   );

   xu_alu #(.WORD_W(WORD_W)) u_alu (
      .lhs (head_lhs),
      .rhs (head_rhs),
      .op  (head_op),
      .res (out_value)
   );

   xu_fanout #(.N_DST(N_DST)) u_fan (
      .clk       (clk),
      .rst_n     (rst_n),
      .head_ok   (!fifo_empty),
      .dst_vld   (head_vld),
      .out_full  (out_full),
      .out_valid (out_valid),
      .cur_idx   (cur_idx),
      .pop       (fifo_pop)
   );

   assign out_node = head_node[cur_idx*NODE_W +: NODE_W];
   assign out_side = head_side[cur_idx];
endmodule

// File: rtl/xu_exec_chk.sv
module xu_exec_chk #(
   parameter int WORD_W = 16,
   parameter int NODE_W = 7,
   parameter int N_DST  = 4,
   parameter int DEPTH  = 4,
   localparam int IDX_W = (N_DST > 1) ? $clog2(N_DST) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_full,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_value,
   input logic [NODE_W-1:0] out_node,
   input logic              out_side,
   input logic              out_full,
   input logic              fifo_pop,
   input logic              fifo_empty,
   input logic [N_DST-1:0]  head_vld,
   input logic [IDX_W-1:0]  cur_idx
);
   logic [CW-1:0] occ_q;

   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else occ_q <= occ_q + CW'(in_valid && !in_full) - CW'(fifo_pop && !fifo_empty);
   end

   a_r9_full_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
      in_full == (occ_q == CW'(DEPTH)));

   a_r7_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_full) |=> (out_valid && $stable(out_value) && $stable(out_node) && $stable(out_side)));

   a_r6_pop_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && out_valid) |-> !out_full);

   a_r8_silent_drop_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && !out_valid) |-> (head_vld == '0));

   a_r5_ascending_slots: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_full && !fifo_pop) |=> (out_valid && cur_idx > $past(cur_idx)));

   a_r10_nothing_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !out_valid);
endmodule

bind xu_exec_unit xu_exec_chk #(
   .WORD_W(WORD_W), .NODE_W(NODE_W), .N_DST(N_DST), .DEPTH(DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_full    (in_full),
   .out_valid  (out_valid),
   .out_value  (out_value),
   .out_node   (out_node),
   .out_side   (out_side),
   .out_full   (out_full),
   .fifo_pop   (fifo_pop),
   .fifo_empty (fifo_empty),
   .head_vld   (head_vld),
   .cur_idx    (cur_idx)
);

// File: tb/xu_exec_unit_bench.sv
module xu_exec_unit_bench;
   localparam int DEPTH = 4;

   typedef struct packed {
      logic [15:0] lhs;
      logic [15:0] rhs;
      logic [1:0]  op;
      logic [3:0]  vld;
      logic [27:0] node;
      logic [3:0]  side;
   } ext_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_lhs = '0, in_rhs = '0;
   logic [1:0]  in_op = '0;
   logic [3:0]  in_dst_vld = '0, in_dst_side = '0;
   logic [27:0] in_dst_node = '0;
   logic        in_full, out_valid, out_side;
   logic [15:0] out_value;
   logic [6:0]  out_node;
   logic        out_full = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   ext_t      q[$];
   logic [3:0] sent = '0;
   logic       prev_blk = 1'b0;
   logic [15:0] prev_val;
   logic [6:0]  prev_node;
   logic        prev_side;

   always #2 clk = ~clk;

   xu_exec_unit #(.DEPTH(DEPTH)) u_xu_exec_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lhs(in_lhs), .in_rhs(in_rhs),
      .in_op(in_op), .in_dst_vld(in_dst_vld), .in_dst_node(in_dst_node),
      .in_dst_side(in_dst_side), .in_full(in_full), .out_valid(out_valid),
      .out_value(out_value), .out_node(out_node), .out_side(out_side), .out_full(out_full)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
      end
   endtask

   function automatic logic [15:0] calc(input ext_t e);
      logic [15:0] r;
      if (e.op == 2'd0)      r = e.lhs + e.rhs;
      else if (e.op == 2'd1) r = e.lhs - e.rhs;
      else                   r = 16'((32'(e.lhs) * 32'(e.rhs)) % 65536);
      return r;
   endfunction

   // One cycle: drive inputs, compare with the model, advance the model at the edge.
   task automatic cyc(input bit v, input ext_t e, input bit blk);
      ext_t  h;
      logic [3:0] pend;
      int    idx;
      bit    ev, acc, popm;
      string vreq;
      in_valid = v; in_lhs = e.lhs; in_rhs = e.rhs; in_op = e.op;
      in_dst_vld = e.vld; in_dst_node = e.node; in_dst_side = e.side;
      out_full = blk;
      #1;
      ev = 0; idx = 0; pend = '0;
      if (q.size() > 0) begin
         h = q[0];
         pend = h.vld & ~sent;
         for (int k = 3; k >= 0; k--) if (pend[k]) idx = k;
         ev = (pend != 0);
      end
      chk(in_full == (q.size() == DEPTH), "R9", in_full, q.size() == DEPTH);
      chk(out_valid == ev, "R11 R8 R6", out_valid, ev);
      if (prev_blk) begin
         chk(out_valid && out_value == prev_val && out_node == prev_node && out_side == prev_side,
             "R7", out_value, prev_val);
      end
      if (ev && out_valid) begin
         vreq = (h.op == 2'd0) ? "R1" : (h.op == 2'd1) ? "R2" : "R3";
         chk(out_value == calc(h), vreq, $signed(out_value), $signed(calc(h)));
         chk(out_node == h.node[idx*7 +: 7], "R4 R5", out_node, h.node[idx*7 +: 7]);
         chk(out_side == h.side[idx], "R4", out_side, h.side[idx]);
      end
      prev_blk = out_valid && blk;
      prev_val = out_value; prev_node = out_node; prev_side = out_side;
      acc  = ev && !blk;
      popm = (q.size() > 0) && (!ev || (acc && ((pend & ~(4'b1 << idx)) == 0)));
      @(posedge clk);
      cycles++;
      if (popm) begin
         void'(q.pop_front());
         sent = '0;
      end else if (acc) begin
         sent[idx] = 1'b1;
      end
      if (v && (q.size() + (popm ? 1 : 0)) < DEPTH) q.push_back(e);
      @(negedge clk);
   endtask

   function automatic ext_t mk(input int a, input int b, input int op, input logic [3:0] vld,
                               input int n0, input int n1, input int n2, input int n3,
                               input logic [3:0] side);
      ext_t e;
      e.lhs = 16'(a); e.rhs = 16'(b); e.op = 2'(op); e.vld = vld;
      e.node = {7'(n3), 7'(n2), 7'(n1), 7'(n0)}; e.side = side;
      return e;
   endfunction

   task automatic idle(input int n, input bit blk);
      for (int i = 0; i < n; i++) cyc(1'b0, '0, blk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!out_valid, "R10", out_valid, 0);
      chk(!in_full, "R10", in_full, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !in_full, "R10", out_valid, 0);

      // R1 R2 R3 R11: single-destination tokens, including wrap cases
      cyc(1, mk(3, 4, 0, 4'b0001, 0, 0, 0, 0, 4'b0000), 0);
      cyc(1, mk(7, 35, 1, 4'b0001, 1, 0, 0, 0, 4'b0001), 0);
      cyc(1, mk(7, -28, 2, 4'b0001, 5, 0, 0, 0, 4'b0000), 0);
      cyc(1, mk(32767, 1, 0, 4'b0001, 9, 0, 0, 0, 4'b0001), 0);
      cyc(1, mk(300, 300, 2, 4'b0001, 127, 0, 0, 0, 4'b0000), 0);
      cyc(1, mk(-5, 32767, 1, 4'b0001, 64, 0, 0, 0, 4'b0001), 0);
      idle(4, 0);

      // R5 R6: sparse and full fan-out, back to back
      cyc(1, mk(10, 20, 0, 4'b1010, 11, 22, 33, 44, 4'b1000), 0);
      cyc(1, mk(6, 7, 2, 4'b1111, 1, 2, 3, 4, 4'b0101), 0);
      cyc(1, mk(100, 1, 1, 4'b0100, 0, 0, 77, 0, 4'b0100), 0);
      idle(8, 0);

      // R7: back-pressure in the middle of a fan-out
      cyc(1, mk(-1, -1, 2, 4'b1101, 3, 4, 5, 6, 4'b0010), 0);
      idle(1, 0);
      idle(3, 1);
      idle(1, 0);
      idle(2, 1);
      idle(4, 0);

      // R8: no-destination tokens between normal ones
      cyc(1, mk(1, 2, 0, 4'b0000, 0, 0, 0, 0, 4'b0000), 0);
      cyc(1, mk(8, 9, 0, 4'b0001, 12, 0, 0, 0, 4'b0000), 0);
      cyc(1, mk(1, 1, 1, 4'b0000, 0, 0, 0, 0, 4'b1111), 0);
      cyc(1, mk(2, 3, 2, 4'b1000, 0, 0, 0, 99, 4'b1000), 0);
      idle(5, 0);

      // R9: fill the FIFO while blocked; the extra write is ignored
      for (int i = 0; i < 6; i++)
         cyc(1, mk(i, 100, 0, 4'b0011, i, i + 40, 0, 0, 4'b0010), 1);
      idle(2, 1);
      idle(14, 0);
      chk(!out_valid && !in_full, "R9", out_valid, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule